// File: doc/BRIEF.md
# Serial Watchdog Timeout Configuration Port

This block is a serial slave on a four-wire bus in clock-idle-low, sample-on-rise mode, bits sent most significant first. It receives one-byte commands and keeps a two-bit timeout selection, which it hands to a separate watchdog counter on `wd_sel`. The serial pins are brought into the system clock domain through two-flop synchronizers. Edges of the serial clock and chip select are detected in that domain.

Changing the selection takes two transactions. Command 8'h06 arms a change-enable latch, and command 8'h04 disarms it. Command 8'h01, followed by a data byte, then requests the new selection. The request is accepted only if four things hold: the latch is armed, the reserved data bits are zero, no earlier write is still settling, and chip select rises after exactly sixteen bits. An accepted request starts a busy period that stands in for a slow nonvolatile write. When the period ends, the new selection appears on `wd_sel` and the latch disarms itself. Command 8'h05 reads the selection back. During a busy period the read returns all ones.

Top module: `wdog_cfg_port`

## Requirements
- R1: After reset, `wd_sel` equals parameter `WD_INIT` (default 2'b00), the change-enable latch is disarmed and `so_oe` is low.
- R2: `so_oe` is high while the synchronized chip select is low and low while it is high. A chip-select fall clears the bit count.
- R3: Command 8'h06, completed at its eighth bit, arms the change-enable latch so that a later write command can take effect.
- R4: Command 8'h04 disarms the latch. A later write command then leaves `wd_sel` unchanged.
- R5: Write command 8'h01 is followed by a data byte in which bit 4 is the upper bit and bit 3 is the lower bit of the new `wd_sel`. When accepted, it sets `wd_sel` to those bits `BUSY_CYCLES` clocks after the synchronized chip-select rise.
- R6: A write ended by chip select after any bit count other than 16 (for example 15 or 17) is ignored.
- R7: A write whose data byte has any of bits 7:5 or 2:0 set is ignored.
- R8: The latch disarms when an accepted write completes, so a second write without a new 8'h06 is ignored.
- R9: Read command 8'h05 returns the byte {3'b000, wd_sel, 3'b000} MSB first. Each bit is placed on `so` after a serial clock fall and is valid at the following rise.
- R10: A read issued while a write is settling returns 8'hFF.
- R11: `wd_sel` changes only at the end of a busy period and keeps its old value during it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the bus master |
| csn | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so`; low means high impedance |
| wd_sel | output | 2 | Timeout selection for the watchdog counter |

## Verification
A wrongly armed or disarmed latch shows up only on a later write: `wd_sel` takes or misses a new value one busy period after that transaction. The bench therefore reads the selection back after every attempted write. A wrong bit count or a wrong reserved-bit decision also appears one busy period after chip select rises. A stale busy flag shows as an 8'hFF read at the next read command. A wrong output-enable shows within three clocks of a chip-select edge.

// File: rtl/wdog_cfg_port.sv
module wdog_cfg_port #(
  parameter int unsigned BUSY_CYCLES = 1000,
  parameter logic [1:0]  WD_INIT     = 2'b00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       csn,
  input  logic       si,
  output logic       so,
  output logic       so_oe,
  output logic [1:0] wd_sel
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  localparam logic [7:0] OP_ARM = 8'h06, OP_DISARM = 8'h04, OP_WR = 8'h01, OP_RD = 8'h05;

  logic [2:0] sck_q, csn_q;
  logic [1:0] si_q;
  logic [4:0] nbits;
  logic [15:0] shreg;
  logic [15:0] shnext;
  logic latch, rd_en, fill;
  logic [7:0] obuf;
  logic [1:0] pend;
  logic [CW-1:0] bcnt;

  wire busy     = bcnt != '0;
  wire sck_rise = sck_q[1] & ~sck_q[2];
  wire sck_fall = ~sck_q[1] & sck_q[2];
  wire cs_fall  = ~csn_q[1] & csn_q[2];
  wire cs_rise  = csn_q[1] & ~csn_q[2];
  wire active   = ~csn_q[1];
  wire byte_end = active & sck_rise & (nbits == 5'd7);
  wire [7:0] opc = shnext[7:0];
  wire wr_ok = cs_rise && nbits == 5'd16 && shreg[15:8] == OP_WR && latch && !busy &&
               shreg[7:5] == 3'b000 && shreg[2:0] == 3'b000;

  assign shnext = {shreg[14:0], si_q[1]};
  assign so_oe  = active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0;
      csn_q <= '1;
      si_q  <= '0;
    end else begin
      sck_q <= {sck_q[1:0], sck};
      csn_q <= {csn_q[1:0], csn};
      si_q  <= {si_q[0], si};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nbits <= '0;
      shreg <= '0;
    end else if (cs_fall) begin
      nbits <= '0;
      shreg <= '0;
    end else if (active && sck_rise) begin
      shreg <= shnext;
      if (nbits != 5'd31) nbits <= nbits + 5'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch <= 1'b0;
    end else if (busy && bcnt == CW'(1)) begin
      latch <= 1'b0;
    end else if (byte_end && !busy) begin
      if (opc == OP_ARM) latch <= 1'b1;
      else if (opc == OP_DISARM) latch <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt   <= '0;
      pend   <= WD_INIT;
      wd_sel <= WD_INIT;
    end else if (wr_ok) begin
      bcnt <= CW'(BUSY_CYCLES);
      pend <= shreg[4:3];
    end else if (busy) begin
      bcnt <= bcnt - CW'(1);
      if (bcnt == CW'(1)) wd_sel <= pend;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_en <= 1'b0;
      fill  <= 1'b0;
      obuf  <= '0;
      so    <= 1'b0;
    end else if (cs_fall) begin
      rd_en <= 1'b0;
      fill  <= 1'b0;
      so    <= 1'b0;
    end else if (byte_end && opc == OP_RD) begin
      rd_en <= 1'b1;
      fill  <= busy;
      obuf  <= busy ? 8'hFF : {3'b000, wd_sel, 3'b000};
    end else if (active && sck_fall && rd_en) begin
      so   <= obuf[7];
      obuf <= {obuf[6:0], fill};
    end
  end
endmodule

module wdog_cfg_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       csn,
  input logic       so_oe,
  input logic [1:0] wd_sel,
  input logic       busy,
  input logic       latch
);
  assert_wd_only_at_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wd_sel) |-> $past(busy));
  assert_hiz_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (csn && $past(csn) && $past(csn, 2) && $past(csn, 3)) |-> !so_oe);
  assert_latch_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !latch);
  assert_write_needs_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(latch));
endmodule

bind wdog_cfg_port wdog_cfg_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .csn(csn), .so_oe(so_oe),
  .wd_sel(wd_sel), .busy(busy), .latch(latch)
);

// File: tb/tb_wdog_cfg_port.sv
module tb_wdog_cfg_port;
  localparam int BUSY = 1000;
  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, csn = 1'b1, si = 1'b0;
  logic so, so_oe;
  logic [1:0] wd_sel;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  wdog_cfg_port #(.BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .csn(csn), .si(si),
    .so(so), .so_oe(so_oe), .wd_sel(wd_sel)
  );

  // {arm_first, opcode, data, bit count, expected wd_sel}
  localparam logic [23:0] VEC [0:9] = '{
    {1'b1, 8'h01, 8'h08, 5'd16, 2'b01},
    {1'b1, 8'h01, 8'h10, 5'd16, 2'b10},
    {1'b0, 8'h01, 8'h18, 5'd16, 2'b10},
    {1'b1, 8'h01, 8'h18, 5'd15, 2'b10},
    {1'b1, 8'h01, 8'h18, 5'd17, 2'b10},
    {1'b1, 8'h01, 8'h38, 5'd16, 2'b10},
    {1'b1, 8'h01, 8'h19, 5'd16, 2'b10},
    {1'b1, 8'h01, 8'h18, 5'd16, 2'b11},
    {1'b0, 8'h01, 8'h00, 5'd16, 2'b11},
    {1'b1, 8'h01, 8'h00, 5'd16, 2'b00}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [23:0] w, input int n, output logic [7:0] rx);
    rx = '0;
    csn = 1'b0;
    ticks(8);
    for (int i = 0; i < n; i++) begin
      si = w[23 - i];
      ticks(8);
      if (i >= 8) rx = {rx[6:0], so};
      sck = 1'b1;
      ticks(8);
      sck = 1'b0;
    end
    ticks(8);
    csn = 1'b1;
    ticks(8);
  endtask

  task automatic rd(output logic [7:0] v);
    xfer({8'h05, 16'h0}, 16, v);
  endtask

  initial begin
    ticks(200000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] rx;
    ticks(4);
    // R1 reset state
    chk("R1 wd_sel", wd_sel, 2'b00);
    chk("R1 so_oe", so_oe, 0);
    rst_n = 1'b1;
    ticks(4);
    // R1 latch disarmed: write without arm is ignored
    xfer({8'h01, 8'h18, 8'h0}, 16, rx);
    ticks(BUSY + 20);
    chk("R1 latch off at reset", wd_sel, 2'b00);
    // R2 output enable follows chip select
    csn = 1'b0; ticks(6);
    chk("R2 so_oe low cs", so_oe, 1);
    csn = 1'b1; ticks(6);
    chk("R2 so_oe high cs", so_oe, 0);

    // R3 R5 R6 R7 R8 R9: vector table
    for (int k = 0; k < 10; k++) begin
      if (VEC[k][23]) xfer({8'h06, 16'h0}, 8, rx);
      xfer({VEC[k][22:7], 8'h00}, int'(VEC[k][6:2]), rx);
      ticks(BUSY + 20);
      chk($sformatf("R5/R6/R7/R8 vec%0d wd_sel", k), wd_sel, VEC[k][1:0]);
      rd(rx);
      chk($sformatf("R9 vec%0d readback", k), rx, {3'b000, VEC[k][1:0], 3'b000});
    end

    // R4 disarm cancels arm
    xfer({8'h06, 16'h0}, 8, rx);
    xfer({8'h04, 16'h0}, 8, rx);
    xfer({8'h01, 8'h10, 8'h0}, 16, rx);
    ticks(BUSY + 20);
    chk("R4 disarmed write ignored", wd_sel, 2'b00);

    // R10 R11 read during busy period
    xfer({8'h06, 16'h0}, 8, rx);
    xfer({8'h01, 8'h18, 8'h0}, 16, rx);
    rd(rx);
    chk("R10 busy read", rx, 8'hFF);
    chk("R11 old value during busy", wd_sel, 2'b00);
    ticks(BUSY + 20);
    chk("R11 new value after busy", wd_sel, 2'b11);
    rd(rx);
    chk("R9 read after busy", rx, 8'h18);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule